// File: doc/BRIEF.md
# UART Interrupt Priority Arbiter

This block is the interrupt arbiter for one serial channel. The channel's line, receive and modem logic produce raw request levels. A 4-bit enable word gates these requests. The arbiter then presents one encoded status value, which names the single most urgent request still pending, together with one interrupt line. While a higher request is pending it hides every lower request. When software services the higher request, the next one becomes visible.

The block owns one request itself: transmit-holding-empty. It keeps a pending flag for that request. The flag is set when the block leaves reset and again on each new empty transition. A write to the holding register clears it, and so does a status read that reported it. The other requests are plain levels, and the logic that generates them clears them. The status value and the interrupt line are registered, so they follow the inputs one clock edge later.

Top module: `uart_irq_arbiter`

## Requirements
- R1: While reset is asserted, the status reads 4'b0001 and the interrupt output is 0.
- R2: The transmit-empty flag is pending when the block leaves reset. With enable bit 1 set, the first clock after reset gives status 4'b0010 and raises the interrupt.
- R3: The status codes are: nothing pending 4'b0001, line error 4'b0110, receive trigger 4'b0100, receive timeout 4'b1100, transmit empty 4'b0010, modem change 4'b0000. No other value ever appears.
- R4: The enable bits map as follows: bit 0 enables receive trigger and receive timeout, bit 1 enables transmit empty, bit 2 enables line error, and bit 3 enables modem change. A request whose enable bit is 0 is never reported and never raises the interrupt.
- R5: Priority runs, from highest to lowest: line error, receive trigger, receive timeout, transmit empty, modem change. Only the highest enabled pending request is reported, and a lower one appears once the higher one drops.
- R6: The interrupt output is 1 exactly when some enabled request is pending, so it always equals the inverse of status bit 0.
- R7: A status read while the reported code is transmit empty clears the transmit-empty flag. A status read while another code is reported leaves the flag unchanged.
- R8: A write to the transmit holding register clears the transmit-empty flag.
- R9: A 0-to-1 transition of the holding-empty input sets the flag. It wins over a clear in the same cycle.
- R10: The status and interrupt outputs reflect the inputs sampled at the preceding clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ier_i | input | 4 | Interrupt enable word |
| line_err_i | input | 1 | Receive line error request level |
| rx_trig_i | input | 1 | Receive trigger level reached |
| rx_tmo_i | input | 1 | Receive timeout request level |
| modem_chg_i | input | 1 | Modem status change request level |
| thr_empty_i | input | 1 | Transmit holding register is empty |
| thr_wr_i | input | 1 | Write strobe to the transmit holding register |
| isr_rd_i | input | 1 | Read strobe of the status register |
| isr_o | output | 4 | Encoded highest pending request |
| irq_o | output | 1 | Interrupt output |

## Verification
A status read that clears the transmit-empty flag can land in the same cycle as a fresh empty transition. The bench provokes this by lowering the empty input for one cycle and then raising it in the very cycle the read strobe is high. The flag must survive, so the status has to still read transmit empty on the next sample. A read while a line error masks the transmit-empty request is also judged: the flag must remain, and it must surface once the error drops.

// File: rtl/uirq_pkg.sv
package uirq_pkg;
    localparam int IER_W  = 4;
    localparam int CODE_W = 4;

    localparam int EN_RX    = 0;
    localparam int EN_TX    = 1;
    localparam int EN_LINE  = 2;
    localparam int EN_MODEM = 3;

    typedef enum logic [CODE_W-1:0] {
        ST_NONE    = 4'b0001,
        ST_LINE    = 4'b0110,
        ST_RXDATA  = 4'b0100,
        ST_RXTMO   = 4'b1100,
        ST_TXEMPTY = 4'b0010,
        ST_MODEM   = 4'b0000
    } uirq_code_e;

    typedef struct packed {
        logic pend;
        logic empty_prev;
    } thre_st_t;

    typedef struct packed {
        uirq_code_e code;
        logic       irq;
    } out_st_t;
endpackage

// File: rtl/uirq_thre_tracker.sv
module uirq_thre_tracker
    import uirq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic thr_empty_i,
    input  logic thr_wr_i,
    input  logic isr_rd_i,
    input  logic tx_reported_i,
    output logic pend_d_o,
    output logic pend_o
);
    thre_st_t st_d, st_q;
    logic     rise;
    logic     clr;

    always_comb begin
        st_d            = st_q;
        rise            = thr_empty_i && !st_q.empty_prev;
        clr             = thr_wr_i || (isr_rd_i && tx_reported_i);
        st_d.empty_prev = thr_empty_i;
        if (rise)
            st_d.pend = 1'b1;
        else if (clr)
            st_d.pend = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.pend       <= 1'b1;
            st_q.empty_prev <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign pend_d_o = st_d.pend;
    assign pend_o   = st_q.pend;

    a_r9_rise_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (thr_empty_i && !st_q.empty_prev) |=> pend_o);

    a_r8_wr_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (thr_wr_i && !(thr_empty_i && !st_q.empty_prev)) |=> !pend_o);

    a_r7_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (isr_rd_i && tx_reported_i && !(thr_empty_i && !st_q.empty_prev)) |=> !pend_o);
endmodule

// File: rtl/uirq_prio_enc.sv
module uirq_prio_enc
    import uirq_pkg::*;
(
    input  logic [IER_W-1:0] ier_i,
    input  logic             line_err_i,
    input  logic             rx_trig_i,
    input  logic             rx_tmo_i,
    input  logic             tx_pend_i,
    input  logic             modem_chg_i,
    output uirq_code_e       code_o,
    output logic             any_o
);
    logic line_en, rxd_en, rxt_en, tx_en, mdm_en;

    always_comb begin
        line_en = line_err_i  && ier_i[EN_LINE];
        rxd_en  = rx_trig_i   && ier_i[EN_RX];
        rxt_en  = rx_tmo_i    && ier_i[EN_RX];
        tx_en   = tx_pend_i   && ier_i[EN_TX];
        mdm_en  = modem_chg_i && ier_i[EN_MODEM];
        any_o   = line_en || rxd_en || rxt_en || tx_en || mdm_en;
        if (line_en)     code_o = ST_LINE;
        else if (rxd_en) code_o = ST_RXDATA;
        else if (rxt_en) code_o = ST_RXTMO;
        else if (tx_en)  code_o = ST_TXEMPTY;
        else if (mdm_en) code_o = ST_MODEM;
        else             code_o = ST_NONE;
    end
endmodule

// File: rtl/uart_irq_arbiter.sv
module uart_irq_arbiter
    import uirq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IER_W-1:0]  ier_i,
    input  logic              line_err_i,
    input  logic              rx_trig_i,
    input  logic              rx_tmo_i,
    input  logic              modem_chg_i,
    input  logic              thr_empty_i,
    input  logic              thr_wr_i,
    input  logic              isr_rd_i,
    output logic [CODE_W-1:0] isr_o,
    output logic              irq_o
);
    out_st_t    st_d, st_q;
    uirq_code_e enc_code;
    logic       enc_any;
    logic       tx_pend_d;
    logic       tx_pend_q;
    logic       tx_reported;

    assign tx_reported = (st_q.code == ST_TXEMPTY);

    uirq_thre_tracker u_thre (
        .clk           (clk),
        .rst_n         (rst_n),
        .thr_empty_i   (thr_empty_i),
        .thr_wr_i      (thr_wr_i),
        .isr_rd_i      (isr_rd_i),
        .tx_reported_i (tx_reported),
        .pend_d_o      (tx_pend_d),
        .pend_o        (tx_pend_q)
    );

    uirq_prio_enc u_enc (
        .ier_i       (ier_i),
        .line_err_i  (line_err_i),
        .rx_trig_i   (rx_trig_i),
        .rx_tmo_i    (rx_tmo_i),
        .tx_pend_i   (tx_pend_d),
        .modem_chg_i (modem_chg_i),
        .code_o      (enc_code),
        .any_o       (enc_any)
    );

    always_comb begin
        st_d      = st_q;
        st_d.code = enc_code;
        st_d.irq  = enc_any;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.code <= ST_NONE;
            st_q.irq  <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign isr_o = st_q.code;
    assign irq_o = st_q.irq;

    a_r6_irq_matches_status: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o != isr_o[0]);

    a_r3_legal_code: assert property (@(posedge clk) disable iff (!rst_n)
        isr_o inside {4'b0001, 4'b0110, 4'b0100, 4'b1100, 4'b0010, 4'b0000});

    a_r5_line_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (line_err_i && ier_i[EN_LINE]) |=> (isr_o == 4'b0110));

    a_r4_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (ier_i == '0) |=> (!irq_o && isr_o == 4'b0001));

    a_r2_tx_visible: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_pend_q && ier_i[EN_TX]) |-> (irq_o || $past(!rst_n) || $past(isr_rd_i) || $past(thr_wr_i)
                                        || !$past(ier_i[EN_TX]) || !$past(tx_pend_q)));
endmodule

// File: tb/uart_irq_arbiter_tb.sv
module uart_irq_arbiter_tb;
    logic       clk = 1'b0;
    logic       rst_n;
    logic [3:0] ier;
    logic       line_err, rx_trig, rx_tmo, modem_chg;
    logic       thr_empty, thr_wr, isr_rd;
    logic [3:0] isr;
    logic       irq;
    int         checks = 0;
    int         fails  = 0;
    bit         done   = 1'b0;

    always #2 clk = ~clk;

    uart_irq_arbiter u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .ier_i       (ier),
        .line_err_i  (line_err),
        .rx_trig_i   (rx_trig),
        .rx_tmo_i    (rx_tmo),
        .modem_chg_i (modem_chg),
        .thr_empty_i (thr_empty),
        .thr_wr_i    (thr_wr),
        .isr_rd_i    (isr_rd),
        .isr_o       (isr),
        .irq_o       (irq)
    );

    function automatic logic [3:0] exp_code(logic [3:0] e, logic ln, logic rd, logic rt,
                                            logic tx, logic md);
        if (ln && e[2])      return 4'b0110;
        else if (rd && e[0]) return 4'b0100;
        else if (rt && e[0]) return 4'b1100;
        else if (tx && e[1]) return 4'b0010;
        else if (md && e[3]) return 4'b0000;
        return 4'b0001;
    endfunction

    task automatic chk(string req, logic [3:0] act, logic [3:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; ier = 4'b0010; line_err = 0; rx_trig = 0; rx_tmo = 0; modem_chg = 0;
        thr_empty = 1'b1; thr_wr = 0; isr_rd = 0;
        repeat (3) tick();
        chk("R1 status", isr, 4'b0001);
        chk("R1 irq", {3'b0, irq}, 4'b0000);
        rst_n = 1'b1;
        tick();
        chk("R2 status", isr, 4'b0010);
        chk("R2 irq", {3'b0, irq}, 4'b0001);

        // R3 R4 R5 R6 R10: sweep enables x request levels, with tx flag clear then set
        for (int t = 0; t < 2; t++) begin
            ier = 4'b0000; line_err = 0; rx_trig = 0; rx_tmo = 0; modem_chg = 0;
            if (t == 0) begin
                thr_wr = 1'b1; tick(); thr_wr = 1'b0;
            end else begin
                thr_empty = 1'b0; tick(); thr_empty = 1'b1;
            end
            tick();
            for (int e = 0; e < 16; e++) begin
                for (int s = 0; s < 16; s++) begin
                    ier = 4'(e);
                    line_err = s[0]; rx_trig = s[1]; rx_tmo = s[2]; modem_chg = s[3];
                    tick();
                    chk("R3 R4 R5 R10 code", isr,
                        exp_code(4'(e), s[0], s[1], s[2], t[0], s[3]));
                    chk("R6 irq", {3'b0, irq},
                        {3'b0, exp_code(4'(e), s[0], s[1], s[2], t[0], s[3]) != 4'b0001});
                end
            end
        end

        // R7: read while transmit empty reported clears it
        ier = 4'b0110; line_err = 0; rx_trig = 0; rx_tmo = 0; modem_chg = 0;
        tick();
        chk("R7 pre", isr, 4'b0010);
        isr_rd = 1'b1; tick(); isr_rd = 1'b0;
        chk("R7 cleared", isr, 4'b0001);
        tick();
        chk("R7 stays clear", isr, 4'b0001);

        // R9: new empty transition re-arms
        thr_empty = 1'b0; tick(); thr_empty = 1'b1; tick();
        chk("R9 rearm", isr, 4'b0010);

        // R7 masked read, R5 reveal
        line_err = 1'b1; tick();
        chk("R5 line masks tx", isr, 4'b0110);
        isr_rd = 1'b1; tick(); isr_rd = 1'b0;
        chk("R7 masked read keeps", isr, 4'b0110);
        line_err = 1'b0; tick();
        chk("R5 tx revealed", isr, 4'b0010);

        // R9: rise wins over concurrent read clear
        thr_empty = 1'b0; tick();
        chk("R9 pre", isr, 4'b0010);
        thr_empty = 1'b1; isr_rd = 1'b1; tick(); isr_rd = 1'b0;
        chk("R9 rise beats read", isr, 4'b0010);

        // R8: holding write clears
        thr_wr = 1'b1; tick(); thr_wr = 1'b0;
        chk("R8 write clears", isr, 4'b0001);
        chk("R8 irq low", {3'b0, irq}, 4'b0000);

        // R4: flag pending but disabled stays hidden, then shows when enabled
        thr_empty = 1'b0; tick(); thr_empty = 1'b1; ier = 4'b0000; tick();
        chk("R4 disabled hidden", isr, 4'b0001);
        ier = 4'b0010; tick();
        chk("R4 enabled shows", isr, 4'b0010);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule